// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status

This block keeps one interrupt-enable register and one interrupt-status register for each of five localities and drives a single shared, active-high interrupt line. The arbiter and the command state machine send it event pulses, each tagged with a locality and carrying up to four event kinds: data-available, status-valid, locality-changed and command-ready. An event is recorded in the tagged locality's status register, and raises the line, only if that locality has turned on both its global enable and the matching event enable.

Software reaches the registers through a small access port. It gives a locality, a register select, a byte offset and an access size, and the block aligns the data to the addressed byte lanes. Writes take effect only when they come from the locality that currently owns the interface. Reads return a register immediately from any locality. A read-only vector register reports a fixed line number chosen at build time. The polarity field is held for software, but the output pin is always active-high and level-driven.

Top module: `irq_locality_ctrl`

## Requirements
- R1: After reset every enable register reads 0x0000_0008 (polarity field 2'b01 in bits 4:3), every status register reads 0, and irq_o is 0.
- R2: An event with evt_mask_i bit b set on a valid locality L sets status bit P(b) of L, where P maps 0->0 (data-available), 1->1 (status-valid), 2->2 (locality-changed), 3->7 (command-ready), only when enable bit 31 and enable bit P(b) of L are both 1.
- R3: The clock edge that latches any status bit also sets irq_o, so irq_o is 1 from the next cycle.
- R4: Events tagged with a locality of 5 or more change no status register and do not raise irq_o.
- R5: A write to a status register (acc_sel_i = 1) clears each status bit among 0,1,2,7 that is written as 1. Writing 0 or writing any other bit has no effect, and status bits other than 0,1,2,7 always read 0.
- R6: An enable register write (acc_sel_i = 0) updates only bits 31, 7, 4:3 and 2:0. All other enable bits always read 0.
- R7: A write to the enable or status register is ignored unless acc_loc_i is a valid locality and equals active_loc_i. The value 7 on active_loc_i means that no locality owns the interface.
- R8: The written lanes start at byte acc_off_i and cover 1, 2 or 4 bytes for acc_size_i = 0, 1, or 2/3. wr_data_i is right-aligned and is shifted to that offset. Lanes beyond byte 3 are dropped, and bytes outside the lanes keep their value.
- R9: irq_o drops in the cycle after an accepted status write that clears at least one of bits 0,1,2,7 and leaves the writing locality's status at zero, even if another locality still holds status bits. A status write that leaves bits set keeps irq_o high.
- R10: The vector register (acc_sel_i = 2) reads LINE_NUM in bits 3:0 and zero above, and writes to it have no effect. LINE_NUM must lie in 0..15.
- R11: When an event sets a status bit in the same cycle that an accepted write clears it, the bit ends set and irq_o stays 1.
- R12: rd_data_o shows the selected register of acc_loc_i combinationally. It reads 0 for select 3 and for an invalid locality on selects 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| active_loc_i | input | 3 | Locality that owns the interface; 7 means none |
| evt_valid_i | input | 1 | Event pulse strobe |
| evt_loc_i | input | 3 | Locality tagged on the event |
| evt_mask_i | input | 4 | Event kinds: data-available, status-valid, locality-changed, command-ready |
| acc_loc_i | input | 3 | Locality of the register access |
| acc_sel_i | input | 2 | 0 enable, 1 status, 2 vector, 3 reserved |
| acc_off_i | input | 2 | Byte offset within the 32-bit register |
| acc_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Right-aligned write data |
| rd_data_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Shared interrupt line, active-high |

## Verification
A wrong enable register shows up at once on rd_data_o. Within one cycle it also shows up as a status bit that should have latched but did not, or as a status bit that latched when it should not have. A bad lane decode corrupts neighbouring bytes, and this is visible on the next read of the same register. A fault in the line logic appears on irq_o the cycle after a latch or a clear, and status and line are compared in that cycle. That cycle includes the cross-locality case, where one locality's clear drops the line while another still holds bits.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned GLOBAL_BIT = 31;
  localparam logic [REG_W-1:0] EN_WR_MASK = 32'h8000_009F;
  localparam logic [REG_W-1:0] EVT_BITS   = 32'h0000_0087;
  localparam logic [REG_W-1:0] EN_RST     = 32'h0000_0008;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;

  // event kind index -> status bit position
  function automatic logic [REG_W-1:0] evt_to_bits(logic [3:0] e);
    logic [REG_W-1:0] b;
    b = '0;
    b[0] = e[0];
    b[1] = e[1];
    b[2] = e[2];
    b[7] = e[3];
    return b;
  endfunction
endpackage

// File: rtl/irq_lane_align.sv
module irq_lane_align
  import irq_regs_pkg::*;
(
  input  logic [1:0]       off_i,
  input  logic [1:0]       size_i,
  input  logic [REG_W-1:0] data_i,
  output logic [REG_W-1:0] data_o,
  output logic [REG_W-1:0] bmask_o
);
  logic [3:0] lanes;
  logic [3:0] be;

  always_comb begin
    unique case (size_i)
      2'd0:    lanes = 4'b0001;
      2'd1:    lanes = 4'b0011;
      default: lanes = 4'b1111;
    endcase
    be     = 4'(lanes << off_i);
    data_o = data_i << {off_i, 3'b000};
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign bmask_o[8*i +: 8] = {8{be[i]}};
  end
endmodule

// File: rtl/irq_loc_regs.sv
module irq_loc_regs
  import irq_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       evt_i,
  input  logic             en_we_i,
  input  logic             sts_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] bmask_i,
  output logic [REG_W-1:0] en_o,
  output logic [REG_W-1:0] sts_o,
  output logic [REG_W-1:0] sts_d_o,
  output logic             latch_o
);
  logic [REG_W-1:0] en_q, en_d, sts_q, sts_d, set_bits, clr_bits;

  always_comb begin
    set_bits = evt_to_bits(evt_i) & en_q & {REG_W{en_q[GLOBAL_BIT]}};
    clr_bits = sts_we_i ? (wdata_i & bmask_i & EVT_BITS) : '0;
    sts_d    = (sts_q & ~clr_bits) | set_bits;   // set wins
    en_d     = en_we_i ? ((en_q & ~(bmask_i & EN_WR_MASK)) | (wdata_i & bmask_i & EN_WR_MASK))
                       : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= EN_RST;
      sts_q <= '0;
    end else begin
      en_q  <= en_d;
      sts_q <= sts_d;
    end
  end

  assign en_o    = en_q;
  assign sts_o   = sts_q;
  assign sts_d_o = sts_d;
  assign latch_o = |set_bits;

  assert_sts_reserved_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o & ~EVT_BITS) == '0);
  assert_en_reserved_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o & ~EN_WR_MASK) == '0);
  assert_no_latch_disabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o[GLOBAL_BIT] && !sts_we_i) |=> $stable(sts_o));
  assert_set_beats_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && en_o[GLOBAL_BIT] && |(evt_to_bits(evt_i) & en_o)) |=> (sts_o != '0));
endmodule

// File: rtl/irq_locality_ctrl.sv
module irq_locality_ctrl
  import irq_regs_pkg::*;
#(
  parameter int NUM_LOC  = 5,
  parameter int LOC_W    = 3,
  parameter int LINE_NUM = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LOC_W-1:0] active_loc_i,
  input  logic             evt_valid_i,
  input  logic [LOC_W-1:0] evt_loc_i,
  input  logic [3:0]       evt_mask_i,
  input  logic [LOC_W-1:0] acc_loc_i,
  input  logic [1:0]       acc_sel_i,
  input  logic [1:0]       acc_off_i,
  input  logic [1:0]       acc_size_i,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  output logic [31:0]      rd_data_o,
  output logic             irq_o
);
  if (LINE_NUM < 0 || LINE_NUM > 15) begin : g_bad_line
    $error("LINE_NUM must be within 0..15");
  end

  localparam logic [REG_W-1:0] VEC_VAL = REG_W'(LINE_NUM & 15);

  reg_sel_e sel;
  assign sel = reg_sel_e'(acc_sel_i);

  logic [REG_W-1:0] wdata, bmask;
  logic owner;
  logic [NUM_LOC-1:0][REG_W-1:0] en_q, sts_q, sts_d;
  logic [NUM_LOC-1:0] latch;
  logic irq_q, clr_hit;

  irq_lane_align u_lane (
    .off_i  (acc_off_i),
    .size_i (acc_size_i),
    .data_i (wr_data_i),
    .data_o (wdata),
    .bmask_o(bmask)
  );

  assign owner = wr_en_i && (int'(acc_loc_i) < NUM_LOC) && (acc_loc_i == active_loc_i);

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
    logic [3:0] evt;
    logic       hit;
    assign evt = (evt_valid_i && int'(evt_loc_i) == g) ? evt_mask_i : 4'b0;
    assign hit = owner && int'(acc_loc_i) == g;
    irq_loc_regs u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt),
      .en_we_i (hit && sel == SEL_ENABLE),
      .sts_we_i(hit && sel == SEL_STATUS),
      .wdata_i (wdata),
      .bmask_i (bmask),
      .en_o    (en_q[g]),
      .sts_o   (sts_q[g]),
      .sts_d_o (sts_d[g]),
      .latch_o (latch[g])
    );
  end

  always_comb begin
    clr_hit = 1'b0;
    if (owner && sel == SEL_STATUS && |(wdata & bmask & EVT_BITS)) begin
      for (int i = 0; i < NUM_LOC; i++) begin
        if (int'(acc_loc_i) == i && sts_d[i] == '0) clr_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_q <= 1'b0;
    else if (|latch)   irq_q <= 1'b1;
    else if (clr_hit)  irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  always_comb begin
    rd_data_o = '0;
    unique case (sel)
      SEL_VECTOR: rd_data_o = VEC_VAL;
      SEL_ENABLE, SEL_STATUS: begin
        for (int i = 0; i < NUM_LOC; i++) begin
          if (int'(acc_loc_i) == i) rd_data_o = (sel == SEL_ENABLE) ? en_q[i] : sts_q[i];
        end
      end
      default: rd_data_o = '0;
    endcase
  end

  assert_irq_follows_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sts_q & ~$past(sts_q))) |-> irq_o);
  assert_irq_fall_needs_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_en_i && acc_sel_i == 2'd1));
  assert_foreign_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && acc_loc_i != active_loc_i && !evt_valid_i) |=> ($stable(en_q) && $stable(sts_q)));
  assert_bad_loc_event_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && int'(evt_loc_i) >= NUM_LOC && !wr_en_i) |=> $stable(sts_q));
endmodule

// File: tb/irq_locality_ctrl_bench.sv
module irq_locality_ctrl_bench;
  localparam int LINE = 11;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [2:0] active_loc = 3'd7, evt_loc = '0, acc_loc = '0;
  logic evt_valid = 1'b0, wr_en = 1'b0;
  logic [3:0] evt_mask = '0;
  logic [1:0] acc_sel = '0, acc_off = '0, acc_size = 2'd2;
  logic [31:0] wr_data = '0, rd_data;
  logic irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_locality_ctrl #(.LINE_NUM(LINE)) u_irq_locality_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .active_loc_i(active_loc),
    .evt_valid_i(evt_valid), .evt_loc_i(evt_loc), .evt_mask_i(evt_mask),
    .acc_loc_i(acc_loc), .acc_sel_i(acc_sel), .acc_off_i(acc_off), .acc_size_i(acc_size),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data), .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] loc, input logic [1:0] sel, output logic [31:0] v);
    acc_loc = loc; acc_sel = sel; #1; v = rd_data;
  endtask

  task automatic chk_reg(string req, logic [2:0] loc, logic [1:0] sel, logic [31:0] exp);
    logic [31:0] v;
    rd(loc, sel, v);
    chk(req, v, exp);
  endtask

  // one cycle: optional write and optional event, both applied at the same edge
  task automatic cyc(bit w, logic [2:0] loc, logic [1:0] sel, logic [1:0] off, logic [1:0] sz,
                     logic [31:0] d, bit e, logic [2:0] eloc, logic [3:0] em);
    @(negedge clk);
    wr_en = w; acc_loc = loc; acc_sel = sel; acc_off = off; acc_size = sz; wr_data = d;
    evt_valid = e; evt_loc = eloc; evt_mask = em;
    @(negedge clk);
    wr_en = 1'b0; evt_valid = 1'b0;
  endtask

  task automatic wr(logic [2:0] loc, logic [1:0] sel, logic [1:0] off, logic [1:0] sz, logic [31:0] d);
    cyc(1'b1, loc, sel, off, sz, d, 1'b0, 3'd0, 4'd0);
  endtask

  task automatic ev(logic [2:0] loc, logic [3:0] m);
    cyc(1'b0, 3'd0, 2'd0, 2'd0, 2'd2, 32'h0, 1'b1, loc, m);
  endtask

  task automatic t_reset;
    for (int l = 0; l < 5; l++) begin
      chk_reg("R1 enable", 3'(l), 2'd0, 32'h8);
      chk_reg("R1 status", 3'(l), 2'd1, 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk_reg("R10 vector", 3'd0, 2'd2, LINE);
    chk_reg("R12 reserved select", 3'd0, 2'd3, 32'h0);
    chk_reg("R12 invalid locality", 3'd6, 2'd0, 32'h0);
  endtask

  task automatic t_foreign;
    active_loc = 3'd7;
    wr(3'd0, 2'd0, 2'd0, 2'd2, 32'hFFFF_FFFF);
    chk_reg("R7 no owner", 3'd0, 2'd0, 32'h8);
    active_loc = 3'd1;
    wr(3'd0, 2'd0, 2'd0, 2'd2, 32'hFFFF_FFFF);
    chk_reg("R7 other owner", 3'd0, 2'd0, 32'h8);
    chk_reg("R7 owner untouched", 3'd1, 2'd0, 32'h8);
  endtask

  task automatic t_enable_mask;
    active_loc = 3'd0;
    wr(3'd0, 2'd0, 2'd0, 2'd2, 32'hFFFF_FFFF);
    chk_reg("R6 writable bits", 3'd0, 2'd0, 32'h8000_009F);
  endtask

  task automatic t_disabled_and_invalid;
    ev(3'd1, 4'hF);
    chk_reg("R2 global off", 3'd1, 2'd1, 32'h0);
    chk("R2 irq stays low", {31'b0, irq}, 32'h0);
    ev(3'd5, 4'hF);
    ev(3'd7, 4'hF);
    chk("R4 irq", {31'b0, irq}, 32'h0);
    for (int l = 0; l < 5; l++) chk_reg("R4 status", 3'(l), 2'd1, 32'h0);
  endtask

  task automatic t_latch_and_clear;
    ev(3'd0, 4'b1000);
    chk_reg("R2 command-ready to bit 7", 3'd0, 2'd1, 32'h80);
    chk("R3 irq raised", {31'b0, irq}, 32'h1);
    ev(3'd0, 4'b0111);
    chk_reg("R2 low events", 3'd0, 2'd1, 32'h87);
    wr(3'd0, 2'd1, 2'd0, 2'd2, 32'h80);
    chk_reg("R5 clear bit 7", 3'd0, 2'd1, 32'h07);
    chk("R9 irq held", {31'b0, irq}, 32'h1);
    wr(3'd0, 2'd1, 2'd0, 2'd2, 32'hFFFF_FF00);
    chk_reg("R5 unsupported ones", 3'd0, 2'd1, 32'h07);
    wr(3'd0, 2'd1, 2'd0, 2'd2, 32'h03);
    chk_reg("R5 partial clear", 3'd0, 2'd1, 32'h04);
    chk("R9 irq held nonzero", {31'b0, irq}, 32'h1);
    wr(3'd0, 2'd1, 2'd0, 2'd2, 32'h04);
    chk_reg("R5 all clear", 3'd0, 2'd1, 32'h0);
    chk("R9 irq dropped", {31'b0, irq}, 32'h0);
    wr(3'd0, 2'd0, 2'd0, 2'd2, 32'h8000_0001);
    ev(3'd0, 4'hF);
    chk_reg("R2 only enabled kind", 3'd0, 2'd1, 32'h01);
    wr(3'd0, 2'd1, 2'd0, 2'd2, 32'h01);
  endtask

  task automatic t_lanes;
    wr(3'd0, 2'd0, 2'd3, 2'd0, 32'h00);
    chk_reg("R8 byte lane 3", 3'd0, 2'd0, 32'h0000_0001);
    wr(3'd0, 2'd0, 2'd0, 2'd1, 32'h001E);
    chk_reg("R8 half lanes 1:0", 3'd0, 2'd0, 32'h0000_001E);
    wr(3'd0, 2'd0, 2'd2, 2'd1, 32'h8000);
    chk_reg("R8 half lanes 3:2", 3'd0, 2'd0, 32'h8000_001E);
    wr(3'd0, 2'd0, 2'd1, 2'd0, 32'hFF);
    chk_reg("R8 byte lane 1", 3'd0, 2'd0, 32'h8000_001E);
    wr(3'd0, 2'd0, 2'd3, 2'd1, 32'h0000);
    chk_reg("R8 lane past end", 3'd0, 2'd0, 32'h0000_001E);
    wr(3'd0, 2'd0, 2'd0, 2'd2, 32'h8000_0001);
  endtask

  task automatic t_set_wins;
    ev(3'd0, 4'b0001);
    cyc(1'b1, 3'd0, 2'd1, 2'd0, 2'd2, 32'h1, 1'b1, 3'd0, 4'b0001);
    chk_reg("R11 set wins", 3'd0, 2'd1, 32'h1);
    chk("R11 irq held", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_cross_loc;
    active_loc = 3'd2;
    wr(3'd2, 2'd0, 2'd0, 2'd2, 32'h8000_0004);
    ev(3'd2, 4'b0100);
    chk_reg("R2 locality 2", 3'd2, 2'd1, 32'h4);
    wr(3'd2, 2'd1, 2'd0, 2'd2, 32'h4);
    chk("R9 drop despite other locality", {31'b0, irq}, 32'h0);
    chk_reg("R9 other locality kept", 3'd0, 2'd1, 32'h1);
  endtask

  task automatic t_vector;
    wr(3'd2, 2'd2, 2'd0, 2'd2, 32'h0);
    chk_reg("R10 vector after write", 3'd2, 2'd2, LINE);
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_foreign();
    t_enable_mask();
    t_disabled_and_invalid();
    t_latch_and_clear();
    t_lanes();
    t_set_wins();
    t_cross_loc();
    t_vector();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule